// File: doc/BRIEF.md
# Frame Preemption Verify Sequencer

This block runs the link-partner verification handshake that must succeed before a port may preempt frames. Software controls it through two registers: a control word carrying a link-failure hold bit, a verify-bypass bit and an 8-bit mask of preemptible traffic classes, and a timeout word counting wire-side clock cycles. While the link-failure bit is set the sequencer sits in reset. Clearing the bit starts a handshake: a verify request pulse goes to the frame generator, and the sequencer waits for a good respond indication from the receive side. An unanswered request is sent again after the timeout, up to three times, before the handshake is declared failed.

The receive side also reports incoming verify frames, which the block answers with a respond request pulse, and flags malformed frames. Four status bits report the outcome: verified, verify failed, unexpected respond, and malformed frame. The class mask reaches the preemption datapath only while the port is verified or verification is bypassed. A separate output asserts preemption globally whenever any port has receive-side preemption enabled.

Top module: `fp_verify_seq`

## Requirements
- R1: After reset the control word has the link-failure bit (bit 0) set, the bypass bit (bit 1) clear and the class mask (bits 9:2) zero; the timeout reads 0x1312D0; all four status bits, both request pulses, the effective mask and the global enable are zero.
- R2: A timeout write whose bits above the 21-bit field are all zero is visible on `tmo_cfg` one cycle later; a write with any such bit set is rejected and leaves `tmo_cfg` unchanged.
- R3: When the link-failure bit is cleared with the bypass bit clear, `verify_req` is a single-cycle pulse appearing in the second cycle after the control write.
- R4: With a timeout of T and no good respond, each further `verify_req` pulse follows the previous one by T+2 cycles, and exactly four pulses are issued in total.
- R5: T+2 cycles after the fourth unanswered request, `sts_verify_fail` rises and stays set; `sts_verified` and `sts_verify_fail` are never set together.
- R6: A respond indication without the error flag while a request is outstanding sets `sts_verified` in the next cycle, and no further requests are issued.
- R7: A respond indication without the error flag while no request is outstanding (and link-failure clear) sets the sticky `sts_resp_err` in the next cycle.
- R8: A verify or respond indication with `rx_frame_err` set sets the sticky `sts_verify_err` in the next cycle, produces no respond request and is not taken as an answer to a pending request.
- R9: A verify indication without the error flag, with link-failure clear, produces a single-cycle `respond_req` pulse in the next cycle.
- R10: Setting the link-failure bit clears all four status bits in the second cycle after the write and suppresses respond requests while it is held.
- R11: With the bypass bit set and link-failure clear, no verify request is issued and the class mask takes effect without verification.
- R12: `eff_pmask` equals the control mask while verified or bypassed and is zero otherwise; a mask rewrite while verified shows one cycle after the write.
- R13: `glb_pe_en` is the OR of `rx_pe_en`, registered by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Wire-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 10 | Control word: bit 0 link-failure, bit 1 bypass, bits 9:2 class mask |
| tmo_we | input | 1 | Timeout write strobe |
| tmo_wdata | input | 32 | Timeout value in wire clocks |
| rx_verify | input | 1 | Verify frame received |
| rx_respond | input | 1 | Respond frame received |
| rx_frame_err | input | 1 | Qualifies the received frame as malformed |
| rx_pe_en | input | 4 | Per-port receive preemption enables |
| verify_req | output | 1 | Request to send a verify frame (pulse) |
| respond_req | output | 1 | Request to send a respond frame (pulse) |
| sts_verified | output | 1 | Handshake succeeded |
| sts_verify_fail | output | 1 | All requests went unanswered |
| sts_resp_err | output | 1 | Respond received with nothing outstanding |
| sts_verify_err | output | 1 | Malformed verify or respond received |
| eff_pmask | output | 8 | Preemptible class mask as applied |
| tmo_cfg | output | 21 | Current timeout register |
| glb_pe_en | output | 1 | Global preemption enable |

## Verification
Register writes show on `tmo_cfg` and on the mask one cycle after the write, while sequencer actions lag by two cycles because the control bits pass through the register and then the state register. Received indications affect status and `respond_req` in the following cycle, and retransmissions repeat every T+2 cycles. The bench stamps every cycle with a counter, queues the exact cycle number at which each `verify_req` pulse is due, and a monitor compares each observed pulse against the head of that queue; status checks wait until the computed cycle and also check the cycle before where a change is due.

// File: rtl/fpv_pkg.sv
`timescale 1ns/1ps
package fpv_pkg;
  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_BYPASS   = 3'd1,
    ST_SEND     = 3'd2,
    ST_WAIT     = 3'd3,
    ST_VERIFIED = 3'd4,
    ST_FAILED   = 3'd5
  } fpv_state_e;
endpackage

// File: rtl/fpv_cfg_regs.sv
`timescale 1ns/1ps
module fpv_cfg_regs #(
  parameter int NCLASS = 8,
  parameter int TMO_W = 21,
  parameter logic [TMO_W-1:0] TMO_DEFAULT = 21'h1312D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [NCLASS+1:0] ctl_wdata,
  input  logic              tmo_we,
  input  logic [31:0]       tmo_wdata,
  output logic              link_fail,
  output logic              bypass,
  output logic [NCLASS-1:0] pmask,
  output logic [TMO_W-1:0]  tmo_val
);
  logic              lf_d, bp_d;
  logic [NCLASS-1:0] pm_d;
  logic [TMO_W-1:0]  tmo_d;
  logic              tmo_fits;

  // upper bits beyond the counter field must all be zero
  assign tmo_fits = ((tmo_wdata >> TMO_W) == 32'd0);

  always_comb begin
    lf_d  = link_fail;
    bp_d  = bypass;
    pm_d  = pmask;
    tmo_d = tmo_val;
    if (ctl_we) begin
      lf_d = ctl_wdata[0];
      bp_d = ctl_wdata[1];
      pm_d = ctl_wdata[NCLASS+1:2];
    end
    if (tmo_we && tmo_fits) begin
      tmo_d = tmo_wdata[TMO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_fail <= 1'b1;
      bypass    <= 1'b0;
      pmask     <= '0;
      tmo_val   <= TMO_DEFAULT;
    end else begin
      link_fail <= lf_d;
      bypass    <= bp_d;
      pmask     <= pm_d;
      tmo_val   <= tmo_d;
    end
  end
endmodule

// File: rtl/fpv_verify_fsm.sv
`timescale 1ns/1ps
module fpv_verify_fsm
  import fpv_pkg::*;
#(
  parameter int TMO_W = 21,
  parameter int NUM_RETRY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_fail,
  input  logic             bypass,
  input  logic [TMO_W-1:0] tmo_val,
  input  logic             rx_verify,
  input  logic             rx_respond,
  input  logic             rx_frame_err,
  output logic             verify_req,
  output logic             respond_req,
  output logic             verified,
  output logic             verify_fail,
  output logic             resp_err,
  output logic             verify_err,
  output logic             pe_active
);
  localparam int NUM_TRIES = NUM_RETRY + 1;
  localparam int TRY_W = $clog2(NUM_TRIES + 1);

  fpv_state_e       state_q, state_d;
  logic [TMO_W-1:0] timer_q, timer_d;
  logic [TRY_W-1:0] tries_q, tries_d;
  logic             resp_err_q, resp_err_d;
  logic             verr_q, verr_d;
  logic             rsp_req_q, rsp_req_d;
  logic             good_resp, bad_frame, timer_en, tries_en;

  assign good_resp = rx_respond && !rx_frame_err;
  assign bad_frame = (rx_verify || rx_respond) && rx_frame_err;

  // next state
  always_comb begin
    state_d = state_q;
    if (link_fail) begin
      state_d = ST_RESET;
    end else if (bypass) begin
      state_d = ST_BYPASS;
    end else begin
      unique case (state_q)
        ST_RESET, ST_BYPASS: state_d = ST_SEND;
        ST_SEND:             state_d = ST_WAIT;
        ST_WAIT: begin
          if (good_resp) begin
            state_d = ST_VERIFIED;
          end else if (timer_q == '0) begin
            state_d = (tries_q == TRY_W'(NUM_TRIES)) ? ST_FAILED : ST_SEND;
          end
        end
        ST_VERIFIED, ST_FAILED: state_d = state_q;
        default:             state_d = ST_RESET;
      endcase
    end
  end

  // timer and attempt counter
  always_comb begin
    timer_en = 1'b0;
    timer_d  = timer_q;
    tries_en = 1'b0;
    tries_d  = tries_q;
    if (state_q == ST_SEND) begin
      timer_en = 1'b1;
      timer_d  = tmo_val;
      tries_en = 1'b1;
      tries_d  = tries_q + TRY_W'(1);
    end else if (state_q == ST_WAIT && timer_q != '0) begin
      timer_en = 1'b1;
      timer_d  = timer_q - TMO_W'(1);
    end
    if (state_q == ST_RESET || state_q == ST_BYPASS) begin
      tries_en = 1'b1;
      tries_d  = '0;
    end
  end

  // sticky error flags and respond request
  always_comb begin
    resp_err_d = resp_err_q;
    verr_d     = verr_q;
    rsp_req_d  = 1'b0;
    if (link_fail) begin
      resp_err_d = 1'b0;
      verr_d     = 1'b0;
    end else begin
      if (good_resp && state_q != ST_WAIT) resp_err_d = 1'b1;
      if (bad_frame) verr_d = 1'b1;
      rsp_req_d = rx_verify && !rx_frame_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RESET;
      timer_q    <= '0;
      tries_q    <= '0;
      resp_err_q <= 1'b0;
      verr_q     <= 1'b0;
      rsp_req_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (timer_en) timer_q <= timer_d;
      if (tries_en) tries_q <= tries_d;
      resp_err_q <= resp_err_d;
      verr_q     <= verr_d;
      rsp_req_q  <= rsp_req_d;
    end
  end

  assign verify_req  = (state_q == ST_SEND);
  assign respond_req = rsp_req_q;
  assign verified    = (state_q == ST_VERIFIED);
  assign verify_fail = (state_q == ST_FAILED);
  assign resp_err    = resp_err_q;
  assign verify_err  = verr_q;
  assign pe_active   = (state_q == ST_VERIFIED) || (state_q == ST_BYPASS);
endmodule

// File: rtl/fpv_glb_enable.sv
`timescale 1ns/1ps
module fpv_glb_enable #(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] rx_pe_en,
  output logic              glb_pe_en
);
  logic any_d;

  always_comb begin
    any_d = 1'b0;
    for (int i = 0; i < NPORTS; i++) any_d = any_d | rx_pe_en[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_pe_en <= 1'b0;
    else        glb_pe_en <= any_d;
  end
endmodule

// File: rtl/fp_verify_seq.sv
`timescale 1ns/1ps
module fp_verify_seq #(
  parameter int NCLASS = 8,
  parameter int TMO_W = 21,
  parameter logic [TMO_W-1:0] TMO_DEFAULT = 21'h1312D0,
  parameter int NUM_RETRY = 3,
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [NCLASS+1:0] ctl_wdata,
  input  logic              tmo_we,
  input  logic [31:0]       tmo_wdata,
  input  logic              rx_verify,
  input  logic              rx_respond,
  input  logic              rx_frame_err,
  input  logic [NPORTS-1:0] rx_pe_en,
  output logic              verify_req,
  output logic              respond_req,
  output logic              sts_verified,
  output logic              sts_verify_fail,
  output logic              sts_resp_err,
  output logic              sts_verify_err,
  output logic [NCLASS-1:0] eff_pmask,
  output logic [TMO_W-1:0]  tmo_cfg,
  output logic              glb_pe_en
);
  logic              link_fail, bypass, pe_active;
  logic [NCLASS-1:0] pmask;

  fpv_cfg_regs #(.NCLASS(NCLASS), .TMO_W(TMO_W), .TMO_DEFAULT(TMO_DEFAULT)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
    .link_fail(link_fail), .bypass(bypass), .pmask(pmask), .tmo_val(tmo_cfg)
  );

  fpv_verify_fsm #(.TMO_W(TMO_W), .NUM_RETRY(NUM_RETRY)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .link_fail(link_fail), .bypass(bypass), .tmo_val(tmo_cfg),
    .rx_verify(rx_verify), .rx_respond(rx_respond), .rx_frame_err(rx_frame_err),
    .verify_req(verify_req), .respond_req(respond_req),
    .verified(sts_verified), .verify_fail(sts_verify_fail),
    .resp_err(sts_resp_err), .verify_err(sts_verify_err),
    .pe_active(pe_active)
  );

  fpv_glb_enable #(.NPORTS(NPORTS)) glb_i (
    .clk(clk), .rst_n(rst_n), .rx_pe_en(rx_pe_en), .glb_pe_en(glb_pe_en)
  );

  assign eff_pmask = pe_active ? pmask : '0;
endmodule

// File: rtl/fp_verify_seq_chk.sv
`timescale 1ns/1ps
module fp_verify_seq_chk #(
  parameter int NCLASS = 8,
  parameter int TMO_W = 21,
  parameter int NPORTS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_fail,
  input logic              bypass,
  input logic              tmo_we,
  input logic [31:0]       tmo_wdata,
  input logic [TMO_W-1:0]  tmo_cfg,
  input logic              rx_respond,
  input logic              rx_frame_err,
  input logic [NPORTS-1:0] rx_pe_en,
  input logic              verify_req,
  input logic              sts_verified,
  input logic              sts_verify_fail,
  input logic              sts_resp_err,
  input logic              sts_verify_err,
  input logic [NCLASS-1:0] eff_pmask,
  input logic              glb_pe_en
);
  // R2
  tmo_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_we && ((tmo_wdata >> TMO_W) != 32'd0)) |=> $stable(tmo_cfg));

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verify_req |=> !verify_req);

  // R5
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sts_verified, sts_verify_fail}));

  // R6
  verify_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_verified) |-> $past(rx_respond && !rx_frame_err));

  // R10
  linkfail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail |=> !(sts_verified || sts_verify_fail || sts_resp_err || sts_verify_err));

  // R11
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(bypass)) |-> !verify_req);

  // R12
  pmask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_pmask != '0) |-> (sts_verified || bypass || $past(bypass)));

  // R13
  glb_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pe_en != '0) |=> glb_pe_en);

  // R13
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pe_en == '0) |=> !glb_pe_en);
endmodule

bind fp_verify_seq fp_verify_seq_chk #(.NCLASS(NCLASS), .TMO_W(TMO_W), .NPORTS(NPORTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .link_fail(link_fail), .bypass(bypass),
  .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .tmo_cfg(tmo_cfg),
  .rx_respond(rx_respond), .rx_frame_err(rx_frame_err), .rx_pe_en(rx_pe_en),
  .verify_req(verify_req), .sts_verified(sts_verified),
  .sts_verify_fail(sts_verify_fail), .sts_resp_err(sts_resp_err),
  .sts_verify_err(sts_verify_err), .eff_pmask(eff_pmask), .glb_pe_en(glb_pe_en)
);

// File: tb/fp_verify_seq_tb_top.sv
`timescale 1ns/1ps
module fp_verify_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [9:0]  ctl_wdata = '0;
  logic        tmo_we = 1'b0;
  logic [31:0] tmo_wdata = '0;
  logic        rx_verify = 1'b0;
  logic        rx_respond = 1'b0;
  logic        rx_frame_err = 1'b0;
  logic [3:0]  rx_pe_en = '0;
  logic        verify_req, respond_req;
  logic        sts_verified, sts_verify_fail, sts_resp_err, sts_verify_err;
  logic [7:0]  eff_pmask;
  logic [20:0] tmo_cfg;
  logic        glb_pe_en;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int exp_q[$];

  fp_verify_seq dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .rx_verify(rx_verify),
    .rx_respond(rx_respond), .rx_frame_err(rx_frame_err), .rx_pe_en(rx_pe_en),
    .verify_req(verify_req), .respond_req(respond_req),
    .sts_verified(sts_verified), .sts_verify_fail(sts_verify_fail),
    .sts_resp_err(sts_resp_err), .sts_verify_err(sts_verify_err),
    .eff_pmask(eff_pmask), .tmo_cfg(tmo_cfg), .glb_pe_en(glb_pe_en)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: every verify request pulse must match the queued cycle
  always @(negedge clk) begin
    if (rst_n && verify_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected verify_req actual=%0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R4 verify_req cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  // tasks are entered and left at a falling edge
  task automatic wr_ctl(input bit lf, input bit bp, input logic [7:0] m, output int c);
    c = cyc;
    ctl_we = 1'b1;
    ctl_wdata = {m, bp, lf};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_tmo(input logic [31:0] v);
    tmo_we = 1'b1;
    tmo_wdata = v;
    @(negedge clk);
    tmo_we = 1'b0;
  endtask

  task automatic rx_pulse(input bit v, input bit r, input bit e, output int d);
    d = cyc;
    rx_verify = v;
    rx_respond = r;
    rx_frame_err = e;
    @(negedge clk);
    rx_verify = 1'b0;
    rx_respond = 1'b0;
    rx_frame_err = 1'b0;
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  initial begin
    int c, d, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tmo_cfg == 21'h1312D0, "R1 tmo default", tmo_cfg, 21'h1312D0);
    chk({sts_verified, sts_verify_fail, sts_resp_err, sts_verify_err} == 4'b0, "R1 status", {sts_verified, sts_verify_fail, sts_resp_err, sts_verify_err}, 0);
    chk(!verify_req && !respond_req, "R1 requests", {verify_req, respond_req}, 0);
    chk(eff_pmask == 8'h00 && !glb_pe_en, "R1 mask/glb", {glb_pe_en, eff_pmask}, 0);

    // R2 timeout register accept and reject
    wr_tmo(32'd4);
    chk(tmo_cfg == 21'd4, "R2 accept", tmo_cfg, 4);
    wr_tmo(32'h0020_0004);
    chk(tmo_cfg == 21'd4, "R2 reject", tmo_cfg, 4);
    t = 4;

    // R4 R5 four unanswered requests then failure
    wr_ctl(1'b0, 1'b0, 8'hA5, c);
    for (int k = 0; k < 4; k++) exp_q.push_back(c + 2 + k * (t + 2));
    wait_to(c + 1 + 4 * (t + 2));
    chk(!sts_verify_fail, "R5 before due", sts_verify_fail, 0);
    @(negedge clk);
    chk(sts_verify_fail, "R5 fail set", sts_verify_fail, 1);
    chk(eff_pmask == 8'h00, "R12 failed masks", eff_pmask, 0);
    chk(exp_q.size() == 0, "R4 four requests", exp_q.size(), 0);

    // R10 link fail clears
    wr_ctl(1'b1, 1'b0, 8'hA5, c);
    wait_to(c + 2);
    chk(!sts_verify_fail, "R10 clear fail", sts_verify_fail, 0);

    // R6 good respond
    wr_ctl(1'b0, 1'b0, 8'hA5, c);
    exp_q.push_back(c + 2);
    wait_to(c + 4);
    chk(!sts_verified, "R6 before respond", sts_verified, 0);
    rx_pulse(1'b0, 1'b1, 1'b0, d);
    chk(sts_verified, "R6 verified", sts_verified, 1);
    chk(eff_pmask == 8'hA5, "R12 mask applied", eff_pmask, 8'hA5);
    wait_to(cyc + 20);
    chk(sts_verified && exp_q.size() == 0, "R6 no more requests", exp_q.size(), 0);

    // R7 respond with nothing outstanding
    rx_pulse(1'b0, 1'b1, 1'b0, d);
    chk(sts_resp_err, "R7 resp_err", sts_resp_err, 1);
    chk(sts_verified, "R7 still verified", sts_verified, 1);

    // R8 malformed verify
    rx_pulse(1'b1, 1'b0, 1'b1, d);
    chk(sts_verify_err, "R8 verify_err", sts_verify_err, 1);
    chk(!respond_req, "R8 no respond", respond_req, 0);

    // R9 good verify answered
    rx_pulse(1'b1, 1'b0, 1'b0, d);
    chk(respond_req, "R9 respond_req", respond_req, 1);
    @(negedge clk);
    chk(!respond_req, "R9 pulse width", respond_req, 0);

    // R12 mask rewrite while verified
    wr_ctl(1'b0, 1'b0, 8'h3C, c);
    chk(eff_pmask == 8'h3C, "R12 mask rewrite", eff_pmask, 8'h3C);

    // R10 link fail clears everything and blocks responses
    wr_ctl(1'b1, 1'b0, 8'h3C, c);
    wait_to(c + 2);
    chk({sts_verified, sts_verify_fail, sts_resp_err, sts_verify_err} == 4'b0, "R10 status cleared", {sts_verified, sts_verify_fail, sts_resp_err, sts_verify_err}, 0);
    chk(eff_pmask == 8'h00, "R12 masked in reset", eff_pmask, 0);
    rx_pulse(1'b1, 1'b0, 1'b0, d);
    chk(!respond_req, "R10 respond suppressed", respond_req, 0);

    // R8 malformed respond is not an answer
    wr_ctl(1'b0, 1'b0, 8'h3C, c);
    exp_q.push_back(c + 2);
    exp_q.push_back(c + 2 + (t + 2));
    wait_to(c + 4);
    rx_pulse(1'b0, 1'b1, 1'b1, d);
    chk(sts_verify_err && !sts_verified, "R8 not answer", {sts_verify_err, sts_verified}, 2);
    wait_to(c + 9);
    rx_pulse(1'b0, 1'b1, 1'b0, d);
    chk(sts_verified, "R6 after retry", sts_verified, 1);

    // R11 bypass
    wr_ctl(1'b1, 1'b0, 8'h0F, c);
    wr_ctl(1'b0, 1'b1, 8'h0F, c);
    wait_to(c + 2);
    chk(eff_pmask == 8'h0F, "R11 bypass mask", eff_pmask, 8'h0F);
    chk(!sts_verified, "R11 not verified", sts_verified, 0);
    wait_to(cyc + 20);
    chk(exp_q.size() == 0 && !sts_verify_fail, "R11 no requests", sts_verify_fail, 0);

    // R3 zero timeout: request timing and back-to-back retries
    wr_tmo(32'd0);
    chk(tmo_cfg == 21'd0, "R2 zero accept", tmo_cfg, 0);
    t = 0;
    wr_ctl(1'b1, 1'b0, 8'h00, c);
    wr_ctl(1'b0, 1'b0, 8'h00, c);
    chk(!verify_req, "R3 not early", verify_req, 0);
    for (int k = 0; k < 4; k++) exp_q.push_back(c + 2 + k * (t + 2));
    wait_to(c + 1 + 4 * (t + 2));
    chk(!sts_verify_fail, "R5 zero tmo before", sts_verify_fail, 0);
    @(negedge clk);
    chk(sts_verify_fail, "R5 zero tmo fail", sts_verify_fail, 1);

    // R13 global enable
    rx_pe_en = 4'b0100;
    d = cyc;
    chk(!glb_pe_en, "R13 not yet", glb_pe_en, 0);
    @(negedge clk);
    chk(glb_pe_en, "R13 on", glb_pe_en, 1);
    rx_pe_en = 4'b0000;
    @(negedge clk);
    chk(!glb_pe_en, "R13 off", glb_pe_en, 0);

    chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule